// File: doc/BRIEF.md
# RTC Prescaler with Digital Trim

This block turns an oscillator clock-enable, nominally 32,768 pulses per second, into a one-clock seconds tick and a one-clock minute tick. It trims the clock rate by changing the length of selected seconds. A 5-bit magnitude sets how much trim is applied, and a sign bit sets its direction. The trim is applied in whole steps of the divide-by-256 stage. A positive setting removes one full stage period (256 counts) from a second, so the clock runs faster. A negative setting adds half a stage period (128 counts), so the clock runs slower.

The block tracks its own second and minute position inside a repeating 64-minute cycle. For a magnitude N, only the first second of each of the first 2·N minutes of the cycle is altered. The last two minutes of the cycle are never altered. The trim setting is captured at each minute boundary, and also while reset is held. A change therefore takes effect from the next minute.

A 512 Hz square wave, taken from an untrimmed counter, lets production test measure the raw oscillator rate. A stop input freezes all counting.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, `sec_tick`, `min_tick` and `ft_out` are 0 after that edge. Reset clears the divider, the second position and the minute-in-cycle position.
- R2: With no trim in force, each second lasts exactly OSC_HZ counted enables. `sec_tick` is high for one clock, in the cycle after the enable that completes the second.
- R3: When `cal_pos`=1, a trimmed second lasts OSC_HZ−STAGE counted enables.
- R4: When `cal_pos`=0, a trimmed second lasts OSC_HZ+STAGE/2 counted enables.
- R5: Only second 0 of minutes 0 to 2·N−1 of the 64-minute cycle is trimmed, where N is `cal_mag`. Every other second keeps its nominal length.
- R6: `min_tick` rises together with the `sec_tick` that closes second SEC_PER_MIN−1 of a minute, and at no other time. Minute 64 wraps back to minute 0 of a new cycle, and that minute is trimmed again.
- R7: `cal_mag` and `cal_pos` are captured while reset is held and at each minute boundary. A change made inside a minute leaves that minute unaffected.
- R8: `ft_out` is a square wave that toggles every OSC_HZ/(2·FT_HZ) counted enables. Its period does not depend on the trim setting.
- R9: While `stop`=1, the divider, the ticks and `ft_out` hold. When `stop` is cleared, counting resumes from the held count.
- R10: A clock with `osc_en`=0 does not advance the divider or the test counter.
- R11: `cal_mag`=31 trims 62 minutes. Minutes 62 and 63 are always nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | 1 halts all counting |
| cal_mag | input | MAG_W | Trim magnitude N |
| cal_pos | input | 1 | 1 = faster (shorter second), 0 = slower |
| sec_tick | output | 1 | One-clock pulse per second |
| min_tick | output | 1 | One-clock pulse per minute |
| ft_out | output | 1 | Untrimmed frequency-test square wave |

## Verification
The bench builds the block with OSC_HZ=64, STAGE=16, SEC_PER_MIN=4 and FT_HZ=8. MIN_PER_CYC stays at 64 and MAG_W stays at 5. With these values a full 64-minute trim cycle and its wrap into the next cycle take about 16k clocks. Every second of the cycle can therefore be timed for several magnitudes and both signs, including the full magnitude of 31. The same settings give a trimmed second of 48 enables, a nominal second of 64 and a slowed second of 72. These three lengths are distinct, so the bench can tell which kind of second it is timing. The test toggle period is 4 enables.

// File: rtl/rtc_trim_prescaler.sv
`timescale 1ns/1ps
module rtc_trim_prescaler #(
  parameter int OSC_HZ      = 32768,
  parameter int STAGE       = 256,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int FT_HZ       = 512,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             sec_tick,
  output logic             min_tick,
  output logic             ft_out
);
  localparam int SHORT   = OSC_HZ - STAGE;
  localparam int LONG    = OSC_HZ + STAGE / 2;
  localparam int DIV_W   = $clog2(LONG);
  localparam int SEC_W   = $clog2(SEC_PER_MIN);
  localparam int MIN_W   = $clog2(MIN_PER_CYC);
  localparam int MOD_MAX = MIN_PER_CYC - 2;
  localparam int FT_HALF = OSC_HZ / (2 * FT_HZ);
  localparam int FT_W    = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [SEC_W-1:0] sec_pos;
  logic [MIN_W-1:0] min_pos;
  logic [MAG_W-1:0] mag_q;
  logic             pos_q;
  logic [FT_W-1:0]  ft_cnt;
  logic             adv, trim_sec, sec_end, min_end;
  logic [DIV_W-1:0] top;

  assign adv      = osc_en & ~stop;
  assign trim_sec = (sec_pos == '0) && (int'(min_pos) < 2 * int'(mag_q))
                    && (int'(min_pos) < MOD_MAX);

  always_comb begin
    if (!trim_sec)  top = DIV_W'(OSC_HZ - 1);
    else if (pos_q) top = DIV_W'(SHORT - 1);
    else            top = DIV_W'(LONG - 1);
  end

  assign sec_end = adv && (div_cnt == top);
  assign min_end = sec_end && (sec_pos == SEC_W'(SEC_PER_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      sec_pos  <= '0;
      min_pos  <= '0;
      sec_tick <= 1'b0;
      min_tick <= 1'b0;
      mag_q    <= cal_mag;
      pos_q    <= cal_pos;
    end else begin
      sec_tick <= sec_end;
      min_tick <= min_end;
      if (adv) div_cnt <= sec_end ? '0 : div_cnt + 1'b1;
      if (sec_end) sec_pos <= min_end ? '0 : sec_pos + 1'b1;
      if (min_end) begin
        min_pos <= (min_pos == MIN_W'(MIN_PER_CYC - 1)) ? '0 : min_pos + 1'b1;
        mag_q   <= cal_mag;
        pos_q   <= cal_pos;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_cnt <= '0;
      ft_out <= 1'b0;
    end else if (adv) begin
      if (ft_cnt == FT_W'(FT_HALF - 1)) begin
        ft_cnt <= '0;
        ft_out <= ~ft_out;
      end else begin
        ft_cnt <= ft_cnt + 1'b1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !sec_tick && !min_tick && !ft_out);

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  p_min_on_sec_r6: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_tick);

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sec_tick && $stable(ft_out) && $stable(div_cnt));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !sec_tick && $stable(ft_out) && $stable(div_cnt));

  p_tail_nominal_r11: assert property (@(posedge clk) disable iff (rst)
    (sec_end && int'(min_pos) >= MOD_MAX) |-> (div_cnt == DIV_W'(OSC_HZ - 1)));
endmodule

// File: tb/sim_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module sim_rtc_trim_prescaler;
  localparam int OSC = 64, STG = 16, SPM = 4, FTH = 8;
  localparam int NOM = OSC, FAST = OSC - STG, SLOW = OSC + STG / 2;
  localparam int FT_HALF = OSC / (2 * FTH);
  localparam int NV = 5;
  localparam int VEC_MAG  [NV] = '{0, 1, 3, 31, 31};
  localparam bit VEC_POS  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int VEC_MODS [NV] = '{0, 2, 6, 62, 62};
  localparam int NSEC = 258;

  logic clk = 0, rst = 1, osc_en = 0, stop = 0, cal_pos = 0;
  logic [4:0] cal_mag = '0;
  logic sec_tick, min_tick, ft_out;

  rtc_trim_prescaler #(.OSC_HZ(OSC), .STAGE(STG), .SEC_PER_MIN(SPM),
    .MIN_PER_CYC(64), .FT_HZ(FTH), .MAG_W(5)) u0 (
    .clk(clk), .rst(rst), .osc_en(osc_en), .stop(stop), .cal_mag(cal_mag),
    .cal_pos(cal_pos), .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc, last, nsec, ft_last, ft_bad, ft_tog, min_bad;
  logic ft_prev;
  int lens [0:299];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; last = 1; ft_last = 1; nsec = 0;
      ft_bad = 0; ft_tog = 0; min_bad = 0; ft_prev = 1'b0;
    end else begin
      cyc++;
      if (sec_tick) begin
        if (nsec < 300) lens[nsec] = cyc - last;
        if (min_tick != ((nsec % SPM) == SPM - 1)) min_bad++;
        last = cyc;
        nsec++;
      end else if (min_tick) min_bad++;
      if (ft_out !== ft_prev) begin
        if (cyc - ft_last != FT_HALF) ft_bad++;
        ft_last = cyc;
        ft_tog++;
        ft_prev = ft_out;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mag, input bit pos);
    @(posedge clk); #2;
    rst = 1; cal_mag = 5'(mag); cal_pos = pos; osc_en = 1; stop = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
  endtask

  task automatic wait_secs(input int n);
    while (nsec < n) @(posedge clk);
  endtask

  function automatic int exp_len(input int s, input int mods, input bit pos);
    int m = (s / SPM) % 64;
    if ((s % SPM) == 0 && m < mods) return pos ? FAST : SLOW;
    return NOM;
  endfunction

  function automatic string tag_of(input int s, input int mods, input bit pos);
    int m = (s / SPM) % 64;
    if (s >= 256) return "R6 cycle wrap";
    if (mods == 62 && m >= 62) return "R11 tail minutes";
    if ((s % SPM) == 0 && m < mods) return pos ? "R3 fast second" : "R4 slow second";
    if (mods > 0) return "R5 untouched second";
    return "R2 nominal second";
  endfunction

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int held_n, held_ft;
    // R1: outputs quiet while reset is held
    osc_en = 1; rst = 1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 sec_tick in reset", int'(sec_tick), 0);
    chk("R1 min_tick in reset", int'(min_tick), 0);
    chk("R1 ft_out in reset", int'(ft_out), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset(VEC_MAG[v], VEC_POS[v]);
      wait_secs(NSEC);
      for (int s = 0; s < NSEC; s++)
        chk(tag_of(s, VEC_MODS[v], VEC_POS[v]), lens[s],
            exp_len(s, VEC_MODS[v], VEC_POS[v]));
      chk("R6 minute tick placement", min_bad, 0);
      chk("R8 ft half period", ft_bad, 0);
      chk("R8 ft running", int'(ft_tog > 1000), 1);
    end

    // R7: change inside minute 0 only applies from minute 1
    do_reset(0, 1'b1);
    repeat (10) @(posedge clk);
    #2 cal_mag = 5'd5;
    wait_secs(6);
    chk("R7 minute 0 keeps old setting", lens[0], NOM);
    chk("R7 minute 1 uses new setting", lens[4], FAST);
    chk("R7 second 1 of minute 1", lens[5], NOM);

    // R9: stop freezes the divider and the test output
    do_reset(0, 1'b1);
    repeat (20) @(posedge clk);
    #2 stop = 1;
    held_n = nsec; held_ft = int'(ft_out);
    repeat (300) @(posedge clk);
    chk("R9 no tick while stopped", nsec, held_n);
    chk("R9 ft held while stopped", int'(ft_out), held_ft);
    #2 stop = 0;
    wait_secs(1);
    chk("R9 resume from held count", lens[0], NOM + 300);

    // R10: enable gating
    do_reset(0, 1'b1);
    while (nsec < 1) begin
      @(posedge clk);
      #2 osc_en = ~osc_en;
    end
    chk("R10 half-rate enable doubles second", lens[0], 2 * NOM - 1);
    @(posedge clk); #2 osc_en = 0;
    held_n = nsec; held_ft = int'(ft_out);
    repeat (200) @(posedge clk);
    chk("R10 no tick without enable", nsec, held_n);
    chk("R10 ft held without enable", int'(ft_out), held_ft);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule